// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the instruction fetch address register. For each fetch address it returns a guessed next address within the same cycle. A small table of two-bit saturating counters predicts whether the branch is taken. A separate direct-mapped cache of branch targets supplies the taken destination. When the counter predicts taken and the target cache holds a matching entry, fetch moves to the cached target at once. In every other case, fetch goes on to the next sequential word at PC+4.

Later in the pipeline, the stage that resolves branches reports each resolved branch on a training port. Each report carries the branch address, the actual direction, the actual destination and a flag marking a wrong guess. The block moves the counter one step toward the actual direction. A taken branch writes its entry in the target cache. A wrong guess raises a redirect in the same cycle, with the corrected address. The training port is a valid/ready stream whose ready is held high, so the resolving stage never sees back-pressure. Every beat presented with valid high is consumed on that clock edge.

Top module: `branch_predictor`

## Requirements
- R1: After reset, every counter holds weak not-taken (01) and every target entry is invalid. Any lookup then gives pred_taken=0, btb_hit=0 and pred_next_pc=fetch_pc+4.
- R2: The counter table is indexed by fetch_pc[2 +: PHT_IDX_W]. Counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. pred_taken is bit 1 of the addressed counter.
- R3: A training beat moves the counter at upd_pc[2 +: PHT_IDX_W] up by one when taken and down by one when not taken. The counter saturates at 11 and at 00.
- R4: A counter in a strong state keeps its predicted direction after one opposite outcome. The direction changes only after two consecutive opposite outcomes.
- R5: The target cache is indexed by pc[2 +: BTB_IDX_W] and tagged with pc[PC_W-1 : 2+BTB_IDX_W]. btb_hit is high only when the indexed entry is valid and its tag equals the lookup tag.
- R6: A taken training beat writes valid, tag and upd_target into the indexed target entry. A not-taken beat leaves that entry unchanged.
- R7: pred_next_pc equals the cached target when btb_hit and pred_taken are both high, and fetch_pc+4 otherwise.
- R8: redirect_valid equals upd_valid AND upd_mispredict in the same cycle. redirect_pc is upd_target for a taken beat and upd_pc+4 for a not-taken beat.
- R9: Training takes effect from the next clock edge. A lookup in the cycle of the training beat sees the state from before that beat.
- R10: For an inner loop branch taken three times and then not taken, repeated over several outer passes, the branch mispredicts once per pass after the first pass. That is half the count of a one-bit scheme.
- R11: upd_ready is high in every cycle out of reset, and each beat with upd_valid high is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_taken | output | 1 | Predicted direction for fetch_pc |
| btb_hit | output | 1 | Target cache holds fetch_pc |
| pred_next_pc | output | PC_W | Guessed next fetch address |
| upd_valid | input | 1 | Training beat present |
| upd_ready | output | 1 | Training beat accepted (always high) |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | PC_W | Actual taken destination |
| upd_mispredict | input | 1 | The earlier guess was wrong |
| redirect_valid | output | 1 | Flush and refetch request |
| redirect_pc | output | PC_W | Corrected fetch address |

## Verification
A lookup and a training beat can land on the same table entry in the same cycle. The bench provokes this by presenting a never-seen branch address on fetch_pc and on upd_pc together. It then checks that the lookup still reports the untrained state, with no hit and not-taken. One cycle later the same lookup must report a hit at the new target. The nested-loop run also does a lookup and a training beat in the same cycle on every iteration. There, the miss count is judged against numbers worked out by hand for both counter widths.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // Saturating step of a two-bit direction counter.
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = ctr_e'(cur + 2'b01);
    end else begin
      if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'b01);
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_dir,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_e ctr_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ctr
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctr_q[g] <= CTR_WNT;
      else if (hit_wr) ctr_q[g] <= ctr_step(ctr_q[g], wr_taken);
    end
  end

  ctr_e rd_ctr;
  assign rd_ctr = ctr_q[rd_idx];
  assign rd_dir = rd_ctr[1];

endmodule

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [TGT_W-1:0] rd_tgt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt
);
  localparam int DEPTH = 1 << IDX_W;

  logic             vld_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TGT_W-1:0] tgt_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        tgt_q[g] <= '0;
      end else if (sel) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= wr_tag;
        tgt_q[g] <= wr_tgt;
      end
    end
  end

  assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_tgt = tgt_q[rd_idx];

endmodule

// File: rtl/bp_redirect.sv
module bp_redirect #(
  parameter int PC_W = 32
) (
  input  logic            upd_fire,
  input  logic            upd_mispredict,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  always_comb begin
    redirect_valid = upd_fire && upd_mispredict;
    redirect_pc    = upd_taken ? upd_target : (upd_pc + STEP);
  end

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
  parameter int PC_W      = 32,
  parameter int PHT_IDX_W = 6,
  parameter int BTB_IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic            btb_hit,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_mispredict,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int TAG_W = PC_W - 2 - BTB_IDX_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic upd_fire;
  assign upd_ready = 1'b1;
  assign upd_fire  = upd_valid && upd_ready;

  logic            dir_rd;
  logic            hit_rd;
  logic [PC_W-1:0] tgt_rd;

  bp_pht #(.IDX_W(PHT_IDX_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (fetch_pc[2 +: PHT_IDX_W]),
    .rd_dir   (dir_rd),
    .wr_en    (upd_fire),
    .wr_idx   (upd_pc[2 +: PHT_IDX_W]),
    .wr_taken (upd_taken)
  );

  bp_btb #(.IDX_W(BTB_IDX_W), .TAG_W(TAG_W), .TGT_W(PC_W)) u_btb (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (fetch_pc[2 +: BTB_IDX_W]),
    .rd_tag (fetch_pc[PC_W-1 : 2+BTB_IDX_W]),
    .rd_hit (hit_rd),
    .rd_tgt (tgt_rd),
    .wr_en  (upd_fire && upd_taken),
    .wr_idx (upd_pc[2 +: BTB_IDX_W]),
    .wr_tag (upd_pc[PC_W-1 : 2+BTB_IDX_W]),
    .wr_tgt (upd_target)
  );

  bp_redirect #(.PC_W(PC_W)) u_redir (
    .upd_fire       (upd_fire),
    .upd_mispredict (upd_mispredict),
    .upd_taken      (upd_taken),
    .upd_pc         (upd_pc),
    .upd_target     (upd_target),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
  );

  assign pred_taken   = dir_rd;
  assign btb_hit      = hit_rd;
  assign pred_next_pc = (hit_rd && dir_rd) ? tgt_rd : (fetch_pc + STEP);

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_taken,
  input logic            btb_hit,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            upd_valid,
  input logic            upd_ready,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target,
  input logic            upd_mispredict,
  input logic            redirect_valid,
  input logic [PC_W-1:0] redirect_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  AST_REDIR_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (upd_valid && upd_mispredict)); // R8

  AST_REDIR_TAKEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && upd_taken) |-> (redirect_pc == upd_target)); // R8

  AST_REDIR_FALL_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !upd_taken) |-> (redirect_pc == upd_pc + STEP)); // R8

  AST_JUMP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_next_pc != fetch_pc + STEP) |-> (btb_hit && pred_taken)); // R7

  AST_ALLOC_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && upd_taken)
      |=> ((fetch_pc != $past(upd_pc)) || btb_hit)); // R6

  AST_TWO_TAKEN_PREDICTS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && $past(upd_valid && upd_taken) && (upd_pc == $past(upd_pc)))
      |=> ((fetch_pc != $past(upd_pc)) || pred_taken)); // R4

  AST_TWO_NOT_PREDICTS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && $past(upd_valid && !upd_taken) && (upd_pc == $past(upd_pc)))
      |=> ((fetch_pc != $past(upd_pc)) || !pred_taken)); // R4

endmodule

bind branch_predictor bp_checker #(.PC_W(PC_W)) u_bp_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_pc       (fetch_pc),
  .pred_taken     (pred_taken),
  .btb_hit        (btb_hit),
  .pred_next_pc   (pred_next_pc),
  .upd_valid      (upd_valid),
  .upd_ready      (upd_ready),
  .upd_pc         (upd_pc),
  .upd_taken      (upd_taken),
  .upd_target     (upd_target),
  .upd_mispredict (upd_mispredict),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc)
);

// File: tb/branch_predictor_bench.sv
`timescale 1ns/1ps
module branch_predictor_bench;
  localparam int PC_W = 32;
  localparam int PHT_IDX_W = 6;
  localparam int BTB_IDX_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_taken, btb_hit, upd_ready, redirect_valid;
  logic [PC_W-1:0] pred_next_pc, redirect_pc;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;
  logic [PC_W-1:0] upd_target = '0;
  logic            upd_mispredict = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  branch_predictor #(.PC_W(PC_W), .PHT_IDX_W(PHT_IDX_W), .BTB_IDX_W(BTB_IDX_W)) u_branch_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .btb_hit(btb_hit), .pred_next_pc(pred_next_pc), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_mispredict(upd_mispredict),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  task automatic chk(input bit ok, input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc);
    @(negedge clk);
    fetch_pc = pc;
    #1;
  endtask

  // One training beat; checks the same-cycle redirect (R8) and ready (R11).
  task automatic train(input logic [PC_W-1:0] pc, input bit tk, input logic [PC_W-1:0] tgt, input bit mis);
    logic [PC_W-1:0] exp_pc;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt; upd_mispredict = mis;
    #1;
    exp_pc = tk ? tgt : pc + 4;
    chk(redirect_valid == mis, "R8 redirect_valid", {31'd0, redirect_valid}, {31'd0, mis});
    if (mis) chk(redirect_pc == exp_pc, "R8 redirect_pc", redirect_pc, exp_pc);
    chk(upd_ready == 1'b1, "R11 upd_ready", {31'd0, upd_ready}, 32'd1);
    @(posedge clk);
    #1 upd_valid = 1'b0; upd_mispredict = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  localparam logic [PC_W-1:0] PC_A     = 32'h0000_0104;
  localparam logic [PC_W-1:0] PC_B     = 32'h0000_0108;
  localparam logic [PC_W-1:0] PC_ALIAS = 32'h0000_0144;
  localparam logic [PC_W-1:0] PC_LOOP  = 32'h0000_040C;
  localparam logic [PC_W-1:0] TGT_A    = 32'h0000_2000;
  localparam logic [PC_W-1:0] TGT_LOOP = 32'h0000_03F0;

  initial begin
    bit seq [11];
    int model;
    int miss2, miss1;
    bit one_bit;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: sweep every counter index after reset
    for (int i = 0; i < (1 << PHT_IDX_W); i++) begin
      logic [PC_W-1:0] p;
      p = PC_W'(i * 4 + 32'h1000 * (i % 3));
      look(p);
      chk(!pred_taken && !btb_hit && pred_next_pc == p + 4, "R1 reset lookup", pred_next_pc, p + 4);
    end

    // R2 R3 R4: saturating counter walk at PC_A, direction = MSB
    seq = '{1,1,1,0,1,0,0,0,0,1,1};
    model = 1;
    for (int k = 0; k < 11; k++) begin
      look(PC_A);
      train(PC_A, seq[k], TGT_A, pred_taken != seq[k]);
      if (seq[k]) model = (model < 3) ? model + 1 : 3;
      else        model = (model > 0) ? model - 1 : 0;
      look(PC_A);
      chk(pred_taken == model[1], "R3 R4 counter direction", {31'd0, pred_taken}, {31'd0, model[1]});
    end

    // R5 R6 R7: hit with taken prediction jumps to cached target
    look(PC_A);
    chk(btb_hit && pred_next_pc == TGT_A, "R7 taken hit next pc", pred_next_pc, TGT_A);
    look(PC_ALIAS);
    chk(!btb_hit, "R5 tag mismatch no hit", {31'd0, btb_hit}, 32'd0);
    chk(pred_next_pc == PC_ALIAS + 4, "R7 miss falls through", pred_next_pc, PC_ALIAS + 4);

    // R6: not-taken beat leaves entry; R7: hit but not-taken falls through
    train(PC_A, 1'b0, 32'hDEAD_0000, 1'b1);
    train(PC_A, 1'b0, 32'hDEAD_0000, 1'b0);
    look(PC_A);
    chk(btb_hit, "R6 not-taken keeps entry", {31'd0, btb_hit}, 32'd1);
    chk(!pred_taken && pred_next_pc == PC_A + 4, "R7 hit with not-taken", pred_next_pc, PC_A + 4);

    // R9: same-cycle lookup and training on a fresh address
    @(negedge clk);
    fetch_pc = PC_B;
    upd_valid = 1'b1; upd_pc = PC_B; upd_taken = 1'b1; upd_target = 32'h0000_5000; upd_mispredict = 1'b1;
    #1;
    chk(!btb_hit && !pred_taken, "R9 same-cycle old state", {31'd0, btb_hit}, 32'd0);
    chk(redirect_valid && redirect_pc == 32'h0000_5000, "R8 taken redirect", redirect_pc, 32'h0000_5000);
    @(posedge clk);
    #1 upd_valid = 1'b0; upd_mispredict = 1'b0;
    chk(btb_hit && pred_taken == 1'b1 && pred_next_pc == 32'h0000_5000, "R9 next-cycle new state", pred_next_pc, 32'h0000_5000);

    // R10: nested loop, inner branch taken 3 times then exits, 5 outer passes
    miss2 = 0; miss1 = 0; one_bit = 1'b0;
    for (int o = 0; o < 5; o++) begin
      for (int it = 0; it < 4; it++) begin
        bit act;
        bit p2;
        act = (it != 3);
        @(negedge clk);
        fetch_pc = PC_LOOP;
        #1;
        p2 = pred_taken;
        if (o > 0) begin
          if (p2 != act) miss2++;
          if (one_bit != act) miss1++;
        end
        one_bit = act;
        upd_valid = 1'b1; upd_pc = PC_LOOP; upd_taken = act; upd_target = TGT_LOOP; upd_mispredict = (p2 != act);
        @(posedge clk);
        #1 upd_valid = 1'b0; upd_mispredict = 1'b0;
      end
    end
    chk(miss2 == 4, "R10 two-bit misses", miss2, 4);
    chk(miss1 == 2 * miss2, "R10 one-bit doubles", miss1, 2 * miss2);
    look(PC_LOOP);
    chk(pred_next_pc == TGT_LOOP, "R10 loop target cached", pred_next_pc, TGT_LOOP);

    finish_run();
  end

endmodule